// File: doc/BRIEF.md
# Impulse Transmitter Pulse Timing Controller

This block turns one symbol per delay-line window into the digital controls of an impulse radio transmitter. A delay-locked loop (outside this block) sweeps a set of equally spaced clock phases, and the block is told which phase is current as a one-hot tap vector. The symbol boundary is the cycle in which tap 0 is reported. At that boundary the block takes the pending symbol and the configuration. It works out a start tap and an end tap, which are the select lines for the phase multiplexers that form the pulse edges. It also works out which driver legs fire and on which side.

Two modulations are offered. In binary antipodal amplitude mode, the data bit picks the polarity: it turns on the positive or the negative half of each parallel H-bridge leg. In pulse position mode, the pulse is always positive and is moved later by a whole number of programmable tap steps. The number of positions is programmable from 2 to 4. Drive strength is the number of legs enabled, always counted from leg 0 upward. While a pulse is in flight its settings cannot change.

Top module: `utx_pulse_timer`

## Requirements
- R1: While reset is asserted, and for the cycles up to the first symbol boundary after it, `start_sel`, `end_sel`, `leg_p` and `leg_n` are all zero.
- R2: In amplitude mode (`cfg_mode`=0), the start tap is `cfg_base_tap`. If `sym_data[0]`=1 the selected legs appear on `leg_p`, and if it is 0 they appear on `leg_n`.
- R3: In position mode (`cfg_mode`=1), the start tap is `cfg_base_tap + k*cfg_ppm_step`. Here k is `sym_data[1:0]` limited to the slot count minus one. The slot count is `cfg_ppm_slots` forced into the range 2..4. Only `leg_p` is driven.
- R4: The end tap is the start tap plus `cfg_width`. Both taps are limited to the last tap, NUM_TAPS-1. When tap t is reported, the legs are on in the next cycle exactly when start <= t < end, so a width of 0 gives no pulse.
- R5: `cfg_legs` gives the number of legs to enable, capped at LEGS. Leg i is enabled when i < that count, so the lowest index is used first.
- R6: `leg_p` and `leg_n` are never both non-zero in the same cycle.
- R7: The symbol inputs and all `cfg_*` inputs are sampled only in a cycle where `phase_oh[0]`=1. A change at any other time has no effect on the outputs of the window in progress.
- R8: If `sym_valid`=0 at a boundary, that window has no pulse: the legs stay zero and both select vectors are zero.
- R9: From the cycle after a boundary that carries a symbol, `start_sel` and `end_sel` are the one-hot codes of that window's start and end taps. They hold those values until the next boundary.
- R10: A cycle with `phase_oh` all zero reports no tap. The legs are zero in the following cycle, and no boundary occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| phase_oh | input | NUM_TAPS | One-hot index of the current delay-line phase, bit 0 marks the boundary |
| sym_valid | input | 1 | A symbol is present for the next window |
| sym_data | input | 2 | Bit 0 is the polarity bit in amplitude mode; bits 1:0 are the slot index in position mode |
| cfg_mode | input | 1 | 0 selects amplitude mode, 1 selects position mode |
| cfg_base_tap | input | TAP_W | Tap at which the pulse starts, before any position offset |
| cfg_ppm_step | input | TAP_W | Taps per position slot |
| cfg_ppm_slots | input | 3 | Number of position slots, forced into the range 2..4 |
| cfg_width | input | TAP_W | Pulse width in taps |
| cfg_legs | input | LEG_W | Number of driver legs to enable |
| start_sel | output | NUM_TAPS | One-hot select for the start-edge phase multiplexer |
| end_sel | output | NUM_TAPS | One-hot select for the end-edge phase multiplexer |
| leg_p | output | LEGS | Positive-side leg enables |
| leg_n | output | LEGS | Negative-side leg enables |

## Verification
The latched window state shows up at the ports within one cycle of each boundary. A wrong start or end tap is visible on `start_sel`/`end_sel` right away. It then appears as legs switching on or off at the wrong reported tap later in the same window. A wrong polarity or a wrong leg count shows on the first tap inside the pulse. A state register that picks up new settings in the middle of a window shows as select lines moving, or as leg patterns changing, before tap 0 comes round again. For that reason the bench changes every input partway through a window and still expects the old pulse.

// File: rtl/utx_pkg.sv
package utx_pkg;
  typedef enum logic {
    MOD_PAM = 1'b0,
    MOD_PPM = 1'b1
  } mod_e;
endpackage

// File: rtl/utx_tap_encoder.sv
// Converts the one-hot phase vector into a tap number and a present flag.
module utx_tap_encoder #(
  parameter int NUM_TAPS = 16,
  parameter int TAP_W    = 4
) (
  input  logic [NUM_TAPS-1:0] phase_oh,
  output logic [TAP_W-1:0]    tap_idx,
  output logic                tap_vld
);
  always_comb begin
    tap_idx = '0;
    for (int i = 0; i < NUM_TAPS; i++) begin
      if (phase_oh[i]) tap_idx = tap_idx | TAP_W'(i);
    end
  end

  assign tap_vld = |phase_oh;
endmodule

// File: rtl/utx_window_calc.sv
// Start and end tap of one pulse window, clamped to the last phase.
module utx_window_calc
  import utx_pkg::*;
#(
  parameter int NUM_TAPS = 16,
  parameter int TAP_W    = 4
) (
  input  mod_e             mode,
  input  logic [1:0]       slot_req,
  input  logic [2:0]       slots_cfg,
  input  logic [TAP_W-1:0] base_tap,
  input  logic [TAP_W-1:0] step_taps,
  input  logic [TAP_W-1:0] width_taps,
  output logic [TAP_W-1:0] start_tap,
  output logic [TAP_W-1:0] end_tap
);
  localparam int              SUM_W = TAP_W + 3;
  localparam logic [SUM_W-1:0] LAST = SUM_W'(NUM_TAPS - 1);

  logic [2:0]       slots_eff;
  logic [2:0]       slot_lim;
  logic [1:0]       slot_idx;
  logic [SUM_W-1:0] raw_start;
  logic [SUM_W-1:0] lim_start;
  logic [SUM_W-1:0] raw_end;
  logic [SUM_W-1:0] lim_end;

  always_comb begin
    if (slots_cfg < 3'd2)      slots_eff = 3'd2;
    else if (slots_cfg > 3'd4) slots_eff = 3'd4;
    else                       slots_eff = slots_cfg;
    slot_lim = slots_eff - 3'd1;

    if (mode == MOD_PAM)                  slot_idx = 2'd0;
    else if ({1'b0, slot_req} > slot_lim) slot_idx = slot_lim[1:0];
    else                                  slot_idx = slot_req;

    raw_start = SUM_W'(base_tap) + SUM_W'(slot_idx) * SUM_W'(step_taps);
    lim_start = (raw_start > LAST) ? LAST : raw_start;
    raw_end   = lim_start + SUM_W'(width_taps);
    lim_end   = (raw_end > LAST) ? LAST : raw_end;
  end

  assign start_tap = lim_start[TAP_W-1:0];
  assign end_tap   = lim_end[TAP_W-1:0];
endmodule

// File: rtl/utx_leg_drive.sv
// Leg masks for each bridge side from strength, mode and polarity bit.
module utx_leg_drive
  import utx_pkg::*;
#(
  parameter int LEGS  = 3,
  parameter int LEG_W = 2
) (
  input  mod_e             mode,
  input  logic             pol_bit,
  input  logic [LEG_W-1:0] leg_count,
  output logic [LEGS-1:0]  mask_p,
  output logic [LEGS-1:0]  mask_n
);
  logic [LEGS-1:0] leg_on;
  logic            positive;

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    assign leg_on[g] = (leg_count > LEG_W'(g));
  end

  assign positive = (mode == MOD_PPM) || pol_bit;
  assign mask_p   = positive ? leg_on : '0;
  assign mask_n   = positive ? '0 : leg_on;
endmodule

// File: rtl/utx_pulse_timer.sv
// Pulse timing controller: latches a symbol and its settings at tap 0,
// then drives leg enables across the tap range of the pulse.
module utx_pulse_timer
  import utx_pkg::*;
#(
  parameter  int NUM_TAPS = 16,
  parameter  int LEGS     = 3,
  localparam int TAP_W    = $clog2(NUM_TAPS),
  localparam int LEG_W    = $clog2(LEGS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TAPS-1:0] phase_oh,
  input  logic                sym_valid,
  input  logic [1:0]          sym_data,
  input  logic                cfg_mode,
  input  logic [TAP_W-1:0]    cfg_base_tap,
  input  logic [TAP_W-1:0]    cfg_ppm_step,
  input  logic [2:0]          cfg_ppm_slots,
  input  logic [TAP_W-1:0]    cfg_width,
  input  logic [LEG_W-1:0]    cfg_legs,
  output logic [NUM_TAPS-1:0] start_sel,
  output logic [NUM_TAPS-1:0] end_sel,
  output logic [LEGS-1:0]     leg_p,
  output logic [LEGS-1:0]     leg_n
);
  // reset: asserted at once, released on the clock after two stages
  logic rst_meta, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_int_n <= rst_meta;
    end
  end

  logic [TAP_W-1:0] tap_idx;
  logic             tap_vld;
  logic             boundary;

  utx_tap_encoder #(.NUM_TAPS(NUM_TAPS), .TAP_W(TAP_W)) i_enc (
    .phase_oh (phase_oh),
    .tap_idx  (tap_idx),
    .tap_vld  (tap_vld)
  );

  assign boundary = phase_oh[0];

  mod_e             new_mode;
  logic [TAP_W-1:0] new_start, new_end;
  logic [LEGS-1:0]  new_mp, new_mn;

  assign new_mode = mod_e'(cfg_mode);

  utx_window_calc #(.NUM_TAPS(NUM_TAPS), .TAP_W(TAP_W)) i_win (
    .mode       (new_mode),
    .slot_req   (sym_data),
    .slots_cfg  (cfg_ppm_slots),
    .base_tap   (cfg_base_tap),
    .step_taps  (cfg_ppm_step),
    .width_taps (cfg_width),
    .start_tap  (new_start),
    .end_tap    (new_end)
  );

  utx_leg_drive #(.LEGS(LEGS), .LEG_W(LEG_W)) i_legs (
    .mode      (new_mode),
    .pol_bit   (sym_data[0]),
    .leg_count (cfg_legs),
    .mask_p    (new_mp),
    .mask_n    (new_mn)
  );

  // window state, loaded only at the boundary
  logic             act_vld_q, act_vld_d;
  logic [TAP_W-1:0] act_start_q, act_start_d;
  logic [TAP_W-1:0] act_end_q, act_end_d;
  logic [LEGS-1:0]  act_mp_q, act_mp_d;
  logic [LEGS-1:0]  act_mn_q, act_mn_d;
  logic [LEGS-1:0]  leg_p_q, leg_p_d;
  logic [LEGS-1:0]  leg_n_q, leg_n_d;
  logic             in_pulse;

  always_comb begin
    act_vld_d   = act_vld_q;
    act_start_d = act_start_q;
    act_end_d   = act_end_q;
    act_mp_d    = act_mp_q;
    act_mn_d    = act_mn_q;
    if (boundary) begin
      act_vld_d   = sym_valid;
      act_start_d = new_start;
      act_end_d   = new_end;
      act_mp_d    = new_mp;
      act_mn_d    = new_mn;
    end
    // the tap-0 cycle already uses the settings it loads
    in_pulse = tap_vld && act_vld_d &&
               (tap_idx >= act_start_d) && (tap_idx < act_end_d);
    leg_p_d  = in_pulse ? act_mp_d : '0;
    leg_n_d  = in_pulse ? act_mn_d : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      act_vld_q   <= 1'b0;
      act_start_q <= '0;
      act_end_q   <= '0;
      act_mp_q    <= '0;
      act_mn_q    <= '0;
    end else if (boundary) begin
      act_vld_q   <= act_vld_d;
      act_start_q <= act_start_d;
      act_end_q   <= act_end_d;
      act_mp_q    <= act_mp_d;
      act_mn_q    <= act_mn_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      leg_p_q <= '0;
      leg_n_q <= '0;
    end else begin
      leg_p_q <= leg_p_d;
      leg_n_q <= leg_n_d;
    end
  end

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_sel
    assign start_sel[g] = act_vld_q && (act_start_q == TAP_W'(g));
    assign end_sel[g]   = act_vld_q && (act_end_q == TAP_W'(g));
  end

  assign leg_p = leg_p_q;
  assign leg_n = leg_n_q;
endmodule

// File: rtl/utx_pulse_timer_chk.sv
module utx_pulse_timer_chk #(
  parameter int NUM_TAPS = 16,
  parameter int LEGS     = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_TAPS-1:0] phase_oh,
  input logic [NUM_TAPS-1:0] start_sel,
  input logic [NUM_TAPS-1:0] end_sel,
  input logic [LEGS-1:0]     leg_p,
  input logic [LEGS-1:0]     leg_n
);
  assert_sides_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !((|leg_p) && (|leg_n)));

  assert_legs_low_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((leg_p & (leg_p + LEGS'(1))) == '0) && ((leg_n & (leg_n + LEGS'(1))) == '0));

  assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_sel) && $onehot0(end_sel));

  assert_sel_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_oh[0] |=> ($stable(start_sel) && $stable(end_sel)));

  assert_no_tap_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_oh == '0) |=> ((leg_p == '0) && (leg_n == '0)));

  assert_empty_window_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_sel == end_sel) |-> ((leg_p == '0) && (leg_n == '0)));
endmodule

bind utx_pulse_timer utx_pulse_timer_chk #(.NUM_TAPS(NUM_TAPS), .LEGS(LEGS)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .phase_oh  (phase_oh),
  .start_sel (start_sel),
  .end_sel   (end_sel),
  .leg_p     (leg_p),
  .leg_n     (leg_n)
);

// File: tb/test_utx_pulse_timer.sv
`timescale 1ns/1ps
module test_utx_pulse_timer;
  localparam int NT = 16;
  localparam int NL = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NT-1:0] phase_oh;
  logic          sym_valid;
  logic [1:0]    sym_data;
  logic          cfg_mode;
  logic [3:0]    cfg_base_tap, cfg_ppm_step, cfg_width;
  logic [2:0]    cfg_ppm_slots;
  logic [1:0]    cfg_legs;
  logic [NT-1:0] start_sel, end_sel;
  logic [NL-1:0] leg_p, leg_n;

  always #2 clk = ~clk;

  utx_pulse_timer #(.NUM_TAPS(NT), .LEGS(NL)) i_utx_pulse_timer (
    .clk(clk), .rst_n(rst_n), .phase_oh(phase_oh), .sym_valid(sym_valid),
    .sym_data(sym_data), .cfg_mode(cfg_mode), .cfg_base_tap(cfg_base_tap),
    .cfg_ppm_step(cfg_ppm_step), .cfg_ppm_slots(cfg_ppm_slots),
    .cfg_width(cfg_width), .cfg_legs(cfg_legs), .start_sel(start_sel),
    .end_sel(end_sel), .leg_p(leg_p), .leg_n(leg_n)
  );

  int    checks = 0;
  int    errors = 0;
  bit    chk_on = 0;
  bit    done   = 0;
  string cur_req = "R1";

  // behavioural reference
  bit          m_vld;
  int          m_st, m_en, m_mp, m_mn;
  logic [NT-1:0] e_ss, e_es;
  logic [NL-1:0] e_p, e_n;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vld = 0; m_st = 0; m_en = 0; m_mp = 0; m_mn = 0;
      e_ss = '0; e_es = '0; e_p = '0; e_n = '0;
    end else begin
      int tap; bit tv;
      tap = 0; tv = 0;
      for (int i = 0; i < NT; i++) if (phase_oh[i]) begin tap = i; tv = 1; end
      if (phase_oh[0]) begin
        int slots, k, cnt, msk;
        slots = (cfg_ppm_slots < 2) ? 2 : (cfg_ppm_slots > 4) ? 4 : cfg_ppm_slots;
        k     = cfg_mode ? ((sym_data > slots - 1) ? slots - 1 : sym_data) : 0;
        m_st  = cfg_base_tap + k * cfg_ppm_step;
        if (m_st > NT - 1) m_st = NT - 1;
        m_en  = m_st + cfg_width;
        if (m_en > NT - 1) m_en = NT - 1;
        cnt   = (cfg_legs > NL) ? NL : cfg_legs;
        msk   = (1 << cnt) - 1;
        m_vld = sym_valid;
        if (cfg_mode || sym_data[0]) begin m_mp = msk; m_mn = 0; end
        else begin m_mp = 0; m_mn = msk; end
      end
      if (tv && m_vld && tap >= m_st && tap < m_en) begin
        e_p = NL'(m_mp); e_n = NL'(m_mn);
      end else begin
        e_p = '0; e_n = '0;
      end
      e_ss = m_vld ? (NT'(1) << m_st) : '0;
      e_es = m_vld ? (NT'(1) << m_en) : '0;
    end
  end

  task automatic check_vec(string what, logic [NT-1:0] act, logic [NT-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      check_vec("start_sel", start_sel, e_ss);
      check_vec("end_sel", end_sel, e_es);
      check_vec("leg_p", NT'(leg_p), NT'(e_p));
      check_vec("leg_n", NT'(leg_n), NT'(e_n));
      checks++;
      if ((|leg_p) && (|leg_n)) begin
        errors++;
        $display("FAIL R6 both sides actual=%b/%b expected one side zero", leg_p, leg_n);
      end
    end
  end

  task automatic tick(int t);
    @(negedge clk);
    phase_oh = (t < 0) ? '0 : (NT'(1) << t);
  endtask

  task automatic window(bit v, logic [1:0] d);
    sym_valid = v; sym_data = d;
    for (int t = 0; t < NT; t++) tick(t);
  endtask

  task automatic set_cfg(bit m, int base, int step, int slots, int width, int legs);
    cfg_mode = m; cfg_base_tap = 4'(base); cfg_ppm_step = 4'(step);
    cfg_ppm_slots = 3'(slots); cfg_width = 4'(width); cfg_legs = 2'(legs);
  endtask

  initial begin
    rst_n = 1'b0; phase_oh = '0; sym_valid = 1'b0; sym_data = 2'd0;
    set_cfg(0, 2, 1, 2, 4, 3);
    repeat (3) @(negedge clk);
    // R1: reset state
    cur_req = "R1";
    chk_on = 1;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    window(1'b0, 2'd0);

    cur_req = "R2";
    set_cfg(0, 2, 1, 2, 4, 3);
    window(1'b1, 2'd1);
    window(1'b1, 2'd0);
    window(1'b1, 2'd3);
    window(1'b1, 2'd2);

    cur_req = "R3";
    for (int k = 0; k < 4; k++) begin
      set_cfg(1, 1, 3, 4, 2, 2);
      window(1'b1, 2'(k));
    end
    set_cfg(1, 1, 3, 3, 2, 2); window(1'b1, 2'd3);   // limited to slot 2
    set_cfg(1, 1, 3, 0, 2, 2); window(1'b1, 2'd3);   // slot count forced to 2
    set_cfg(1, 1, 3, 7, 2, 2); window(1'b1, 2'd3);   // slot count forced to 4

    cur_req = "R4";
    set_cfg(0, 5, 1, 2, 0, 3); window(1'b1, 2'd1);   // zero width
    set_cfg(0, 9, 1, 2, 15, 1); window(1'b1, 2'd1);  // end clamped
    set_cfg(1, 12, 5, 4, 3, 2); window(1'b1, 2'd2);  // start clamped
    set_cfg(0, 0, 1, 2, 3, 3); window(1'b1, 2'd0);   // pulse from tap 0

    cur_req = "R5";
    for (int s = 0; s < 4; s++) begin
      set_cfg(0, 3, 1, 2, 5, s);
      window(1'b1, 2'(s & 1));
    end

    cur_req = "R7";
    set_cfg(0, 4, 1, 2, 6, 2);
    sym_valid = 1'b1; sym_data = 2'd1;
    for (int t = 0; t < NT; t++) begin
      tick(t);
      if (t == 5) begin
        set_cfg(1, 1, 2, 4, 9, 3);
        sym_data = 2'd2; sym_valid = 1'b0;
      end
    end
    window(1'b1, 2'd2);

    cur_req = "R8";
    set_cfg(0, 2, 1, 2, 6, 3);
    window(1'b0, 2'd1);

    cur_req = "R9";
    set_cfg(1, 2, 4, 3, 5, 1);
    window(1'b1, 2'd1);

    cur_req = "R10";
    set_cfg(0, 1, 1, 2, 10, 3);
    sym_valid = 1'b1; sym_data = 2'd1;
    tick(0); tick(1); tick(2); tick(-1); tick(-1); tick(3); tick(4); tick(-1); tick(5);
    tick(-1); tick(-1);
    for (int t = 6; t < NT; t++) tick(t);
    tick(-1); tick(-1);

    cur_req = "R1";
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick(-1);
    chk_on = 0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule